// File: doc/BRIEF.md
# BCD calendar time counter

This block keeps wall-clock time and calendar date entirely in packed BCD. A slow reference tick, given as a one-cycle enable in the system clock domain, passes through a prescaler. The prescaler drives a binary sub-second counter. Each time that counter wraps, the seconds field advances. A chain of BCD fields then carries the count through minutes, hours, weekday, day of month, month, a two-digit year and, optionally, a century byte. The day field rolls over at the true length of the current month, and February gains its 29th day in leap years.

Software reaches the block through a byte-wide indexed register port. Writes are taken on the clock edge and reads are combinational. Through two control registers, software can stop counting, clear the prescaler, load new field values, restart the clock and request a round-to-the-minute adjustment.

A sticky carry flag is raised on every counted seconds advance, and it can drive an interrupt line. Software clears the flag, reads the fields, and then tests the flag again. If the flag is set again, an update landed part-way through the read and the read must be repeated.

Top module: `rtc_bcd_clock`

## Requirements
- R1: After reset all time fields read 00 except day and month, which read 01, and the century, which reads CENT_RESET. Both control registers read 00 and carry_irq is low.
- R2: Index 0 reads the binary sub-second count. The count advances once every PRESCALE cycles with tick_en high while counting runs, and it wraps after SUB_MOD-1. Seconds advance on the clock edge where it wraps. Writes to index 0 have no effect.
- R3: Seconds and minutes count 00 to 59 and hours count 00 to 23 in BCD. Each field returns to 00 after its maximum and carries into the next field.
- R4: At each hours carry, the weekday at index 4 advances 0 to 6 and wraps to 0. The day at index 5 returns to 01 after 30 in BCD months 04, 06, 09 and 11, after 31 in all other months except February, and then carries into the month.
- R5: In February the day returns to 01 after 29 when the BCD year is divisible by 4 (00 included) and after 28 otherwise.
- R6: The month at index 6 wraps from 12 to 01 and carries into the year at index 7. The year wraps from 99 to 00 and, with YEAR4=1, carries into the century at index 8, which wraps from 99 to 00. With YEAR4=0, index 8 reads 00.
- R7: Index 15 bit 0 (run) and bit 3 (enable) are stored and read back. Sub-second, prescaler and field counting happen only while both bits are 1, and all fields hold otherwise.
- R8: Writing index 15 with bit 1 set clears the prescaler and the sub-second count on that edge, taking priority over counting. Bit 1 always reads 0.
- R9: Writing index 15 with bit 2 set forces seconds to 00 on that edge. If seconds were 30 or more, minutes also advance with normal carry. Bit 2 always reads 0. The adjustment acts whether or not the clock runs.
- R10: Index 14 bit 7 is the carry flag. It is set on each counted seconds advance. A write with bit 7 at 0 clears it, a write with bit 7 at 1 leaves it alone, and a set on the same edge as a clearing write wins.
- R11: Index 14 bit 4 is the carry interrupt enable, and carry_irq is high exactly when the flag and this enable are both 1.
- R12: Writes to indices 1 to 8 load seconds, minutes, hours, weekday, day, month, year and century, and the value is read back unchanged. Unused indices read 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle pulse of the slow reference tick |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register index |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data for bus_addr |
| carry_irq | output | 1 | Carry interrupt request |

## Verification
The bench targets the full carry ripple from 23:59:59 on the last day of a century year, where one misplaced carry would leave a stale weekday or an unchanged century. It also drives month ends for 30-day months, leap and non-leap Februaries and the year 00, where a wrong leap test or length table would skip or invent a date. Adjust is tested at seconds 29, 30 and 45, so an off-by-one threshold shows up as a missing or spurious minute. The carry flag is tested with a clearing write placed on the exact edge of a seconds advance, which catches a design that lets the clear win and hides a torn read.

// File: rtl/rtc_core_pkg.sv
package rtc_core_pkg;

   typedef logic [7:0] bcd8_t;

   // Register indices (software-visible order)
   localparam logic [3:0] IDX_SUB  = 4'd0;
   localparam logic [3:0] IDX_SEC  = 4'd1;
   localparam logic [3:0] IDX_MIN  = 4'd2;
   localparam logic [3:0] IDX_HOUR = 4'd3;
   localparam logic [3:0] IDX_WDAY = 4'd4;
   localparam logic [3:0] IDX_DAY  = 4'd5;
   localparam logic [3:0] IDX_MON  = 4'd6;
   localparam logic [3:0] IDX_YEAR = 4'd7;
   localparam logic [3:0] IDX_CENT = 4'd8;
   localparam logic [3:0] IDX_STAT = 4'd14;
   localparam logic [3:0] IDX_CTRL = 4'd15;

   // Bit positions inside the two control bytes
   localparam int CTRL_RUN = 0;
   localparam int CTRL_CLR = 1;
   localparam int CTRL_ADJ = 2;
   localparam int CTRL_EN  = 3;
   localparam int STAT_IE  = 4;
   localparam int STAT_CF  = 7;

   function automatic bcd8_t bcd_next(bcd8_t v);
      if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
      return {v[7:4], v[3:0] + 4'd1};
   endfunction

   // Divisible by 4: an odd tens digit contributes 2 modulo 4
   function automatic logic bcd_leap(bcd8_t yr);
      if (yr[4]) return (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
      return (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
   endfunction

   function automatic bcd8_t days_in_month(bcd8_t mon, bcd8_t yr);
      if (mon == 8'h02) return bcd_leap(yr) ? 8'h29 : 8'h28;
      if (mon == 8'h04 || mon == 8'h06 || mon == 8'h09 || mon == 8'h11) return 8'h30;
      return 8'h31;
   endfunction

   // Field slot order: sec, min, hour, wday, day, mon, year, century
   function automatic bcd8_t field_min(int slot);
      return (slot == 4 || slot == 5) ? 8'h01 : 8'h00;
   endfunction

   function automatic bcd8_t field_max_fixed(int slot);
      case (slot)
         0, 1:    return 8'h59;
         2:       return 8'h23;
         3:       return 8'h06;
         5:       return 8'h12;
         default: return 8'h99;
      endcase
   endfunction

endpackage

// File: rtl/rtc_tick_div.sv
module rtc_tick_div
   import rtc_core_pkg::*;
#(
   parameter int unsigned PRESCALE = 512,
   parameter int unsigned SUB_MOD  = 64,
   localparam int unsigned SUB_W   = (SUB_MOD > 2) ? $clog2(SUB_MOD) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick_en,
   input  logic             clr,
   output logic [SUB_W-1:0] sub_cnt,
   output logic             sec_step
);

   localparam int unsigned PRE_W = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;

   if (PRESCALE < 2) begin : g_bad_pre
      $error("rtc_tick_div: PRESCALE must be at least 2");
   end
   if (SUB_MOD < 2 || SUB_MOD > 256) begin : g_bad_sub
      $error("rtc_tick_div: SUB_MOD must lie in 2..256");
   end

   logic [PRE_W-1:0] pre_q;
   logic             pre_last, sub_last, adv;

   assign pre_last = (pre_q == PRE_W'(PRESCALE - 1));
   assign sub_last = (sub_cnt == SUB_W'(SUB_MOD - 1));
   assign adv      = run & tick_en & ~clr;
   assign sec_step = adv & pre_last & sub_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q   <= '0;
         sub_cnt <= '0;
      end else if (clr) begin
         pre_q   <= '0;
         sub_cnt <= '0;
      end else if (adv) begin
         if (pre_last) begin
            pre_q   <= '0;
            sub_cnt <= sub_last ? '0 : sub_cnt + SUB_W'(1);
         end else begin
            pre_q <= pre_q + PRE_W'(1);
         end
      end
   end

   p_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !clr) |=> $stable(sub_cnt));
   p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (sub_cnt == '0));
   p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      sec_step |=> (sub_cnt == '0));

endmodule

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field
   import rtc_core_pkg::*;
#(
   parameter bcd8_t MIN_VAL = 8'h00,
   parameter bcd8_t RST_VAL = 8'h00
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  inc,
   input  logic  load,
   input  bcd8_t load_val,
   input  bcd8_t wrap_max,
   output bcd8_t value
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    value <= RST_VAL;
      else if (load) value <= load_val;
      else if (inc)  value <= (value == wrap_max) ? MIN_VAL : bcd_next(value);
   end

   p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc && !load) |=> $stable(value));
   p_load_r12: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (value == $past(load_val)));
   p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !load && value != wrap_max) |=> (value != $past(value)));

endmodule

// File: rtl/rtc_bcd_clock.sv
module rtc_bcd_clock
   import rtc_core_pkg::*;
#(
   parameter int unsigned PRESCALE   = 512,
   parameter int unsigned SUB_MOD    = 64,
   parameter bit          YEAR4      = 1'b1,
   parameter bcd8_t       CENT_RESET = 8'h20
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_en,
   input  logic       bus_wr,
   input  logic [3:0] bus_addr,
   input  logic [7:0] bus_wdata,
   output logic [7:0] bus_rdata,
   output logic       carry_irq
);

   localparam int unsigned NUM_F = YEAR4 ? 8 : 7;
   localparam int unsigned SUB_W = (SUB_MOD > 2) ? $clog2(SUB_MOD) : 1;

   if (CENT_RESET[3:0] > 4'd9 || CENT_RESET[7:4] > 4'd9) begin : g_bad_cent
      $error("rtc_bcd_clock: CENT_RESET must be packed BCD");
   end

   // Control state
   logic run_q, en_q, ie_q, cf_q;
   logic wr_ctrl, wr_stat, clr_req, adj_req, run;

   assign wr_ctrl = bus_wr & (bus_addr == IDX_CTRL);
   assign wr_stat = bus_wr & (bus_addr == IDX_STAT);
   assign clr_req = wr_ctrl & bus_wdata[CTRL_CLR];
   assign adj_req = wr_ctrl & bus_wdata[CTRL_ADJ];
   assign run     = run_q & en_q;

   logic [SUB_W-1:0] sub_cnt;
   logic             sec_step;

   rtc_tick_div #(.PRESCALE(PRESCALE), .SUB_MOD(SUB_MOD)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .tick_en  (tick_en),
      .clr      (clr_req),
      .sub_cnt  (sub_cnt),
      .sec_step (sec_step)
   );

   // Field chain
   bcd8_t            fval  [NUM_F];
   bcd8_t            fmax  [NUM_F];
   bcd8_t            flval [NUM_F];
   logic [NUM_F-1:0] finc, fload;
   logic [NUM_F-2:0] fcarry;

   for (genvar i = 0; i < NUM_F; i++) begin : g_field
      localparam bcd8_t MINV = field_min(i);
      localparam bcd8_t RSTV = (i == 7) ? CENT_RESET : MINV;

      if (i == 4) begin : g_dmax
         assign fmax[i] = days_in_month(fval[5], fval[6]);
      end else begin : g_fmax
         assign fmax[i] = field_max_fixed(i);
      end

      if (i == 0) begin : g_inc_sec
         assign finc[i] = sec_step & ~adj_req;
      end else if (i == 1) begin : g_inc_min
         assign finc[i] = fcarry[0] | (adj_req & (fval[0] >= 8'h30));
      end else begin : g_inc_chain
         assign finc[i] = fcarry[i-1];
      end

      // Weekday sits beside the chain: it forwards the hours carry to the day
      if (i == 3) begin : g_cy_pass
         assign fcarry[i] = finc[i];
      end else if (i < NUM_F - 1) begin : g_cy
         assign fcarry[i] = finc[i] & (fval[i] == fmax[i]);
      end

      if (i == 0) begin : g_ld_sec
         assign fload[i] = (bus_wr & (bus_addr == IDX_SEC)) | adj_req;
         assign flval[i] = adj_req ? 8'h00 : bus_wdata;
      end else begin : g_ld
         assign fload[i] = bus_wr & (bus_addr == 4'(i + 1));
         assign flval[i] = bus_wdata;
      end

      rtc_bcd_field #(.MIN_VAL(MINV), .RST_VAL(RSTV)) u_field (
         .clk      (clk),
         .rst_n    (rst_n),
         .inc      (finc[i]),
         .load     (fload[i]),
         .load_val (flval[i]),
         .wrap_max (fmax[i]),
         .value    (fval[i])
      );
   end

   bcd8_t cent_rd;
   if (YEAR4) begin : g_cent
      assign cent_rd = fval[NUM_F-1];
   end else begin : g_nocent
      assign cent_rd = 8'h00;
   end

   // Control registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         en_q  <= 1'b0;
         ie_q  <= 1'b0;
         cf_q  <= 1'b0;
      end else begin
         if (wr_ctrl) begin
            run_q <= bus_wdata[CTRL_RUN];
            en_q  <= bus_wdata[CTRL_EN];
         end
         if (wr_stat) ie_q <= bus_wdata[STAT_IE];
         if (sec_step)                             cf_q <= 1'b1;
         else if (wr_stat && !bus_wdata[STAT_CF])  cf_q <= 1'b0;
      end
   end

   assign carry_irq = cf_q & ie_q;

   always_comb begin
      bus_rdata = 8'h00;
      case (bus_addr)
         IDX_SUB:  bus_rdata = 8'(sub_cnt);
         IDX_SEC:  bus_rdata = fval[0];
         IDX_MIN:  bus_rdata = fval[1];
         IDX_HOUR: bus_rdata = fval[2];
         IDX_WDAY: bus_rdata = fval[3];
         IDX_DAY:  bus_rdata = fval[4];
         IDX_MON:  bus_rdata = fval[5];
         IDX_YEAR: bus_rdata = fval[6];
         IDX_CENT: bus_rdata = cent_rd;
         IDX_STAT: begin
            bus_rdata[STAT_CF] = cf_q;
            bus_rdata[STAT_IE] = ie_q;
         end
         IDX_CTRL: begin
            bus_rdata[CTRL_RUN] = run_q;
            bus_rdata[CTRL_EN]  = en_q;
         end
         default:  bus_rdata = 8'h00;
      endcase
   end

   p_cf_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
      sec_step |=> cf_q);
   p_cf_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cf_q) |-> $past(sec_step));
   p_irq_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stat && !bus_wdata[STAT_IE]) |=> !carry_irq);
   p_adjust_r9: assert property (@(posedge clk) disable iff (!rst_n)
      adj_req |=> (fval[0] == 8'h00));
   p_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> !sec_step);

endmodule

// File: tb/rtc_bcd_clock_tb_top.sv
`timescale 1ns/1ps
module rtc_bcd_clock_tb_top;

   localparam int P = 4;
   localparam int S = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_en = 1'b1;
   logic       bus_wr = 1'b0;
   logic [3:0] bus_addr = 4'd0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       carry_irq;

   int checks = 0;
   int errors = 0;
   bit sb_on = 1'b0;

   always #2.5 clk = ~clk;

   rtc_bcd_clock #(.PRESCALE(P), .SUB_MOD(S), .YEAR4(1'b1), .CENT_RESET(8'h20)) dut_i (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .carry_irq(carry_irq)
   );

   // ---------------- behavioural reference (binary integers) ----------------
   int m_pre, m_sub, m_sec, m_min, m_hr, m_wd, m_day, m_mon, m_yr, m_ce;
   bit m_run, m_en, m_ie, m_cf;

   function automatic int b2i(input logic [7:0] v);
      return int'(v[7:4]) * 10 + int'(v[3:0]);
   endfunction

   function automatic logic [7:0] i2b(input int v);
      return 8'(((v / 10) << 4) | (v % 10));
   endfunction

   function automatic int mlen(input int mon, input int yr);
      if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
      if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
      return 31;
   endfunction

   always @(posedge clk) begin : model
      bit step, minc, hinc, dinc, moinc, yinc, cinc, clr, adj;
      if (!rst_n) begin
         m_pre = 0; m_sub = 0; m_sec = 0; m_min = 0; m_hr = 0; m_wd = 0;
         m_day = 1; m_mon = 1; m_yr = 0; m_ce = 20;
         m_run = 0; m_en = 0; m_ie = 0; m_cf = 0;
      end else begin
         step = 0; minc = 0; hinc = 0; dinc = 0; moinc = 0; yinc = 0; cinc = 0;
         clr = bus_wr && bus_addr == 15 && bus_wdata[1];
         adj = bus_wr && bus_addr == 15 && bus_wdata[2];
         if (clr) begin
            m_pre = 0; m_sub = 0;
         end else if (m_run && m_en && tick_en) begin
            m_pre++;
            if (m_pre == P) begin
               m_pre = 0; m_sub++;
               if (m_sub == S) begin m_sub = 0; step = 1; end
            end
         end
         if (adj) begin
            minc = (m_sec >= 30); m_sec = 0;
         end else if (step) begin
            if (m_sec == 59) begin m_sec = 0; minc = 1; end else m_sec++;
         end
         if (minc) begin if (m_min == 59) begin m_min = 0; hinc = 1; end else m_min++; end
         if (hinc) begin if (m_hr == 23) begin m_hr = 0; dinc = 1; end else m_hr++; end
         if (dinc) begin
            m_wd = (m_wd + 1) % 7;
            if (m_day == mlen(m_mon, m_yr)) begin m_day = 1; moinc = 1; end else m_day++;
         end
         if (moinc) begin if (m_mon == 12) begin m_mon = 1; yinc = 1; end else m_mon++; end
         if (yinc) begin if (m_yr == 99) begin m_yr = 0; cinc = 1; end else m_yr++; end
         if (cinc) m_ce = (m_ce == 99) ? 0 : m_ce + 1;
         if (bus_wr) begin
            case (bus_addr)
               4'd1: m_sec = b2i(bus_wdata);
               4'd2: m_min = b2i(bus_wdata);
               4'd3: m_hr  = b2i(bus_wdata);
               4'd4: m_wd  = b2i(bus_wdata);
               4'd5: m_day = b2i(bus_wdata);
               4'd6: m_mon = b2i(bus_wdata);
               4'd7: m_yr  = b2i(bus_wdata);
               4'd8: m_ce  = b2i(bus_wdata);
               4'd14: begin m_ie = bus_wdata[4]; if (!bus_wdata[7]) m_cf = 0; end
               4'd15: begin m_run = bus_wdata[0]; m_en = bus_wdata[3]; end
               default: ;
            endcase
         end
         if (step) m_cf = 1;
      end
   end

   function automatic logic [7:0] exp_read(input logic [3:0] a);
      case (a)
         4'd0: return 8'(m_sub);
         4'd1: return i2b(m_sec);
         4'd2: return i2b(m_min);
         4'd3: return i2b(m_hr);
         4'd4: return i2b(m_wd);
         4'd5: return i2b(m_day);
         4'd6: return i2b(m_mon);
         4'd7: return i2b(m_yr);
         4'd8: return i2b(m_ce);
         4'd14: return {m_cf, 2'b00, m_ie, 4'b0000};
         4'd15: return {4'b0000, m_en, 2'b00, m_run};
         default: return 8'h00;
      endcase
   endfunction

   function automatic string tag_of(input logic [3:0] a);
      case (a)
         4'd0: return "R2";
         4'd1, 4'd2, 4'd3: return "R3";
         4'd4, 4'd5: return "R4";
         4'd6, 4'd7, 4'd8: return "R6";
         4'd14: return "R10";
         4'd15: return "R7";
         default: return "R12";
      endcase
   endfunction

   task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s at %0t: got %02h expected %02h", tag, $time, got, exp);
      end
   endtask

   // per-cycle comparison against the reference, away from the active edge
   always @(negedge clk) begin
      if (rst_n && sb_on) begin
         chk(tag_of(bus_addr), bus_rdata, exp_read(bus_addr));
         chk("R11", {7'd0, carry_irq}, {7'd0, m_cf & m_ie});
      end
   end

   task automatic cyc();
      @(posedge clk); #1;
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      cyc();
      bus_wr = 1'b0;
   endtask

   task automatic watch(input int n);
      for (int k = 0; k < n; k++) begin
         bus_addr = bus_addr + 4'd1;
         cyc();
      end
   endtask

   task automatic rd(input logic [3:0] a, input logic [7:0] e, input string tag);
      bus_addr = a;
      @(negedge clk);
      chk(tag, bus_rdata, e);
      cyc();
   endtask

   task automatic set_date(input logic [7:0] wd, input logic [7:0] dy,
                           input logic [7:0] mo, input logic [7:0] yr);
      wr(4'd1, 8'h59); wr(4'd2, 8'h59); wr(4'd3, 8'h23);
      wr(4'd4, wd); wr(4'd5, dy); wr(4'd6, mo); wr(4'd7, yr);
   endtask

   // one counted second: clear prescaler and run, stop after 20 counted edges
   task automatic one_second();
      wr(4'd15, 8'h0B);
      watch(19);
      wr(4'd15, 8'h08);
   endtask

   initial begin : watchdog
      #(200000 * 5);
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      sb_on = 1'b1;

      // R1: reset state
      rd(4'd0, 8'h00, "R1"); rd(4'd1, 8'h00, "R1"); rd(4'd3, 8'h00, "R1");
      rd(4'd5, 8'h01, "R1"); rd(4'd6, 8'h01, "R1"); rd(4'd8, 8'h20, "R1");
      rd(4'd14, 8'h00, "R1"); rd(4'd15, 8'h00, "R1");
      chk("R1", {7'd0, carry_irq}, 8'h00);

      // R2: index 0 is not writable
      wr(4'd0, 8'hFF);
      rd(4'd0, 8'h00, "R2");

      // R12: load and read back every field
      wr(4'd1, 8'h58); wr(4'd2, 8'h59); wr(4'd3, 8'h23); wr(4'd4, 8'h06);
      wr(4'd5, 8'h31); wr(4'd6, 8'h12); wr(4'd7, 8'h99); wr(4'd8, 8'h20);
      rd(4'd1, 8'h58, "R12"); rd(4'd4, 8'h06, "R12"); rd(4'd7, 8'h99, "R12");
      rd(4'd8, 8'h20, "R12"); rd(4'd11, 8'h00, "R12");

      // R3/R4/R6: two seconds across a century boundary
      wr(4'd14, 8'h10);
      wr(4'd15, 8'h0B);
      watch(39);
      wr(4'd15, 8'h08);
      rd(4'd1, 8'h00, "R3"); rd(4'd2, 8'h00, "R3"); rd(4'd3, 8'h00, "R3");
      rd(4'd4, 8'h00, "R4"); rd(4'd5, 8'h01, "R4"); rd(4'd6, 8'h01, "R6");
      rd(4'd7, 8'h00, "R6"); rd(4'd8, 8'h21, "R6"); rd(4'd0, 8'h02, "R2");
      rd(4'd14, 8'h90, "R10");
      chk("R11", {7'd0, carry_irq}, 8'h01);

      // R10: writing 1 to the flag keeps it, writing 0 clears it
      wr(4'd14, 8'h90); rd(4'd14, 8'h90, "R10");
      wr(4'd14, 8'h10); rd(4'd14, 8'h10, "R10");
      chk("R11", {7'd0, carry_irq}, 8'h00);

      // R7: stopped with enable set, then enabled off with run set
      watch(40);
      rd(4'd0, 8'h02, "R7"); rd(4'd1, 8'h00, "R7");
      wr(4'd15, 8'h01);
      watch(40);
      rd(4'd0, 8'h02, "R7"); rd(4'd1, 8'h00, "R7"); rd(4'd15, 8'h01, "R7");
      wr(4'd15, 8'h08);

      // R5: leap February in year 24
      set_date(8'h03, 8'h28, 8'h02, 8'h24);
      one_second();
      rd(4'd5, 8'h29, "R5"); rd(4'd6, 8'h02, "R5"); rd(4'd4, 8'h04, "R4");
      rd(4'd0, 8'h01, "R2");
      // R5: common February in year 23
      set_date(8'h01, 8'h28, 8'h02, 8'h23);
      one_second();
      rd(4'd5, 8'h01, "R5"); rd(4'd6, 8'h03, "R5");
      // R5: year 00 is a leap year
      set_date(8'h02, 8'h28, 8'h02, 8'h00);
      one_second();
      rd(4'd5, 8'h29, "R5");
      // R4: 30-day month ends, 31-day month does not at 30
      set_date(8'h05, 8'h30, 8'h04, 8'h23);
      one_second();
      rd(4'd5, 8'h01, "R4"); rd(4'd6, 8'h05, "R4");
      set_date(8'h05, 8'h30, 8'h05, 8'h23);
      one_second();
      rd(4'd5, 8'h31, "R4"); rd(4'd6, 8'h05, "R4");
      // R4: month 11 has 30 days
      set_date(8'h00, 8'h30, 8'h11, 8'h23);
      one_second();
      rd(4'd5, 8'h01, "R4"); rd(4'd6, 8'h12, "R4");

      // R8: prescaler clear mid-run and read-back of the clear bit
      wr(4'd15, 8'h0B);
      watch(9);
      wr(4'd15, 8'h0B);
      wr(4'd15, 8'h08);
      rd(4'd0, 8'h00, "R8"); rd(4'd15, 8'h08, "R8");

      // R9: adjust at 45, 29 and 30 seconds
      wr(4'd1, 8'h45); wr(4'd2, 8'h59); wr(4'd3, 8'h10);
      wr(4'd15, 8'h0C);
      rd(4'd1, 8'h00, "R9"); rd(4'd2, 8'h00, "R9"); rd(4'd3, 8'h11, "R9");
      rd(4'd15, 8'h08, "R9");
      wr(4'd1, 8'h29); wr(4'd2, 8'h05);
      wr(4'd15, 8'h0C);
      rd(4'd1, 8'h00, "R9"); rd(4'd2, 8'h05, "R9");
      wr(4'd1, 8'h30);
      wr(4'd15, 8'h0C);
      rd(4'd1, 8'h00, "R9"); rd(4'd2, 8'h06, "R9");

      // R10: a clear on the seconds edge loses to the set
      wr(4'd14, 8'h10);
      rd(4'd14, 8'h10, "R10");
      wr(4'd15, 8'h0B);
      watch(15);
      wr(4'd14, 8'h10);
      wr(4'd15, 8'h08);
      rd(4'd14, 8'h90, "R10");
      // R11: flag set but interrupt disabled
      wr(4'd14, 8'h80);
      rd(4'd14, 8'h80, "R11");
      chk("R11", {7'd0, carry_irq}, 8'h00);
      wr(4'd14, 8'h00);
      rd(4'd14, 8'h00, "R10");

      watch(20);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule